// File: doc/BRIEF.md
# Maskable interrupt request front end

This block sits between the interrupt pins of a small processor core and its bus unit. It takes two local interrupt pins. A routing control decides their role. In the legacy role, pin 0 is a maskable interrupt request and pin 1 is a non-maskable request. In the local role, the block only passes the synchronized pins through to a local interrupt controller, and it ignores them as requests.

Both pins are asynchronous, so each one goes through a multi-flop synchronizer. A lockstep input declares that the pins are already synchronous to the bus clock, and then a single sampling register is used instead. A maskable request is held pending until the core reports an instruction boundary while its interrupt-enable flag is set. The block then raises a valid/ready request toward the bus unit, and that request produces exactly one acknowledge transaction. After the acknowledge completes, no new request is recognized until the pin has been sampled low on two consecutive clocks.

A request that is sampled low twice in a row while it is still pending is withdrawn and produces no acknowledge. A rising edge on the non-maskable pin is taken at the next instruction boundary, whatever the enable flag holds. It is reported as a one-cycle pulse.

The maskable path is a four-state machine:
- ST_IDLE goes to ST_PEND on transition T_SEEN, when the synchronized request is high in the legacy role.
- ST_PEND goes to ST_IDLE on T_DROP, when the inactive condition is met or the pins are routed to the local role.
- ST_PEND goes to ST_ACK on T_TAKE, at a boundary with the enable flag set. T_DROP has priority over T_TAKE.
- ST_ACK goes to ST_REARM on T_DONE, when ack_ready is seen.
- ST_REARM goes to ST_IDLE on T_ARM, once the inactive condition holds.

Top module: `intreq_frontend`

## Requirements
- R1: A synchronous active-low reset clears the synchronizers, the pending state, the non-maskable edge state and the low-sample counter. After reset, ack_valid, nmi_take and lint_out are all 0.
- R2: The maskable path has a fixed latency. In the legacy role (route_legacy=1), with int_en and insn_boundary held high, ack_valid rises on the 4th rising clock edge after lpin[0] goes high, and is still low after the 3rd edge. When lockstep_sync=1 it rises on the 3rd edge instead.
- R3: While int_en is low, a maskable request produces no ack_valid and stays pending. It is taken at the first edge that sees int_en and insn_boundary both high.
- R4: ack_valid rises only after an edge at which insn_boundary and int_en were both high.
- R5: ack_valid stays high until ack_ready is high at a rising edge. It is low in the cycle after that handshake.
- R6: A recognized request gives exactly one handshake. Holding lpin[0] high after the acknowledge produces no second handshake.
- R7: A single low sample of the request does not count as deasserted. It neither withdraws a pending request nor re-arms the block after an acknowledge. Two consecutive low samples do re-arm the block, and a later high level is acknowledged again.
- R8: A pending request whose pin is sampled low on two consecutive clocks before the acknowledge starts is withdrawn. Enabling afterwards produces no handshake.
- R9: In the legacy role, a rising level on lpin[1] makes nmi_take pulse high for exactly one cycle at an instruction boundary, independent of int_en. With insn_boundary held high, the pulse follows the same latency as R2.
- R10: When route_legacy=0, lint_out follows the synchronized pins two edges after they change, with bit 0 carrying lpin[0] and bit 1 carrying lpin[1]. In this role no handshake and no nmi_take occur. When route_legacy=1, lint_out is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Synchronous active-low reset |
| lockstep_sync | input | 1 | 1: pins are already synchronous, use a single sampling register |
| route_legacy | input | 1 | 1: pins act as maskable/non-maskable pair; 0: local interrupt role |
| lpin | input | 2 | Local interrupt pins (bit 0 maskable, bit 1 non-maskable in the legacy role) |
| int_en | input | 1 | Interrupt-enable flag from the core |
| insn_boundary | input | 1 | High when the current instruction completes |
| ack_ready | input | 1 | Bus unit accepts the acknowledge request |
| ack_valid | output | 1 | Request to run one interrupt acknowledge transaction |
| nmi_take | output | 1 | One-cycle pulse: non-maskable request taken |
| lint_out | output | 2 | Synchronized pins toward the local controller (local role only) |

## Verification
The maskable acknowledge launch and the non-maskable take can happen in the same cycle. The bench provokes this by raising both pins on the same clock, sweeping every combination of lockstep_sync, int_en and insn_boundary. Where a take is held back, the missing condition is supplied later, so both paths can fire on one edge or on separate edges.

At the exact edge predicted by the fixed latency, the bench judges each output against its own expected value: ack_valid from enable and boundary, and nmi_take from boundary alone. A handshake counter then confirms that exactly one acknowledge resulted in each case.

// File: rtl/ife_pkg.sv
package ife_pkg;
    localparam int NPINS = 2;
    localparam int PIN_MASK = 0;
    localparam int PIN_NMI  = 1;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_PEND,
        ST_ACK,
        ST_REARM
    } mstate_t;
endpackage

// File: rtl/ife_sync.sv
module ife_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic bypass,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chain <= '0;
        end else begin
            chain <= {chain[STAGES-2:0], d};
        end
    end

    // lockstep: first flop is the bus-clock sample; otherwise full chain
    assign q = bypass ? chain[0] : chain[STAGES-1];
endmodule

// File: rtl/ife_mask_fsm.sv
module ife_mask_fsm
    import ife_pkg::*;
#(
    parameter int INACT_SAMPLES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic legacy,
    input  logic s_req,
    input  logic int_en,
    input  logic insn_boundary,
    input  logic ack_ready,
    output logic ack_valid
);
    localparam int CW = $clog2(INACT_SAMPLES + 1);
    localparam logic [CW-1:0] LOW_FULL = CW'(INACT_SAMPLES);

    mstate_t state, nxt;
    logic [CW-1:0] low_cnt;
    logic inactive;

    // consecutive low samples, saturating
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            low_cnt <= '0;
        end else if (s_req) begin
            low_cnt <= '0;
        end else if (low_cnt != LOW_FULL) begin
            low_cnt <= low_cnt + 1'b1;
        end
    end

    assign inactive = (low_cnt == LOW_FULL);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= nxt;
        end
    end

    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE: begin
                if (legacy && s_req) nxt = ST_PEND;               // T_SEEN
            end
            ST_PEND: begin
                if (inactive || !legacy) nxt = ST_IDLE;           // T_DROP
                else if (insn_boundary && int_en) nxt = ST_ACK;   // T_TAKE
            end
            ST_ACK: begin
                if (ack_ready) nxt = ST_REARM;                    // T_DONE
            end
            ST_REARM: begin
                if (inactive) nxt = ST_IDLE;                      // T_ARM
            end
            default: nxt = ST_IDLE;
        endcase
    end

    always_comb begin
        ack_valid = 1'b0;
        unique case (state)
            ST_ACK:  ack_valid = 1'b1;
            default: ack_valid = 1'b0;
        endcase
    end
endmodule

// File: rtl/ife_nmi.sv
module ife_nmi (
    input  logic clk,
    input  logic rst_n,
    input  logic legacy,
    input  logic s_nmi,
    input  logic insn_boundary,
    output logic nmi_take
);
    logic prev, pend, rise;

    assign rise = legacy && s_nmi && !prev;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev     <= 1'b0;
            pend     <= 1'b0;
            nmi_take <= 1'b0;
        end else begin
            prev     <= s_nmi;
            nmi_take <= legacy && pend && insn_boundary;
            if (!legacy) begin
                pend <= 1'b0;
            end else if (pend && insn_boundary) begin
                pend <= 1'b0;
            end else if (rise) begin
                pend <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/intreq_frontend.sv
module intreq_frontend
    import ife_pkg::*;
#(
    parameter int SYNC_STAGES   = 2,
    parameter int INACT_SAMPLES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             lockstep_sync,
    input  logic             route_legacy,
    input  logic [NPINS-1:0] lpin,
    input  logic             int_en,
    input  logic             insn_boundary,
    input  logic             ack_ready,
    output logic             ack_valid,
    output logic             nmi_take,
    output logic [NPINS-1:0] lint_out
);
    logic [NPINS-1:0] s_pin;

    for (genvar i = 0; i < NPINS; i++) begin : g_sync
        ife_sync #(.STAGES(SYNC_STAGES)) u_sync (
            .clk    (clk),
            .rst_n  (rst_n),
            .bypass (lockstep_sync),
            .d      (lpin[i]),
            .q      (s_pin[i])
        );
    end

    ife_mask_fsm #(.INACT_SAMPLES(INACT_SAMPLES)) u_mask (
        .clk           (clk),
        .rst_n         (rst_n),
        .legacy        (route_legacy),
        .s_req         (s_pin[PIN_MASK]),
        .int_en        (int_en),
        .insn_boundary (insn_boundary),
        .ack_ready     (ack_ready),
        .ack_valid     (ack_valid)
    );

    ife_nmi u_nmi (
        .clk           (clk),
        .rst_n         (rst_n),
        .legacy        (route_legacy),
        .s_nmi         (s_pin[PIN_NMI]),
        .insn_boundary (insn_boundary),
        .nmi_take      (nmi_take)
    );

    assign lint_out = route_legacy ? '0 : s_pin;
endmodule

// File: rtl/intreq_frontend_chk.sv
module intreq_frontend_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       route_legacy,
    input logic       int_en,
    input logic       insn_boundary,
    input logic       ack_ready,
    input logic       ack_valid,
    input logic       nmi_take
);
    p_ack_stall_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ack_valid && !ack_ready |=> ack_valid);

    p_ack_once_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ack_valid && ack_ready |=> !ack_valid);

    // R3 and R4: launch needs enable and boundary at the previous edge
    p_ack_gate_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ack_valid) |-> $past(insn_boundary && int_en));

    p_nmi_gate_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(nmi_take) |-> $past(insn_boundary));

    p_nmi_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        nmi_take |=> !nmi_take);

    p_local_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!route_legacy) |-> !nmi_take);
endmodule

bind intreq_frontend intreq_frontend_chk u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .route_legacy  (route_legacy),
    .int_en        (int_en),
    .insn_boundary (insn_boundary),
    .ack_ready     (ack_ready),
    .ack_valid     (ack_valid),
    .nmi_take      (nmi_take)
);

// File: tb/sim_intreq_frontend.sv
`timescale 1ns/1ps
module sim_intreq_frontend;
    localparam int SYNC_STAGES = 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic lockstep_sync = 1'b0;
    logic route_legacy = 1'b0;
    logic [1:0] lpin = 2'b00;
    logic int_en = 1'b0;
    logic insn_boundary = 1'b0;
    logic ack_ready = 1'b0;
    logic ack_valid, nmi_take;
    logic [1:0] lint_out;

    int checks = 0;
    int failures = 0;
    int hs = 0;
    int cyc = 0;

    always #10 clk = ~clk;

    intreq_frontend #(.SYNC_STAGES(SYNC_STAGES)) u0 (
        .clk(clk), .rst_n(rst_n), .lockstep_sync(lockstep_sync),
        .route_legacy(route_legacy), .lpin(lpin), .int_en(int_en),
        .insn_boundary(insn_boundary), .ack_ready(ack_ready),
        .ack_valid(ack_valid), .nmi_take(nmi_take), .lint_out(lint_out)
    );

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (rst_n && ack_valid && ack_ready) hs <= hs + 1;
    end

    task automatic step(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic do_reset(input logic ls, input logic rt);
        rst_n = 1'b0;
        lpin = 2'b00; int_en = 1'b0; insn_boundary = 1'b0; ack_ready = 1'b0;
        lockstep_sync = ls; route_legacy = rt;
        step(2);
        rst_n = 1'b1;
    endtask

    initial begin
        int base;
        int lat;
        do_reset(1'b0, 1'b1);
        chk("R1 ack_valid", int'(ack_valid), 0);
        chk("R1 nmi_take", int'(nmi_take), 0);
        chk("R1 lint_out", int'(lint_out), 0);

        // sweep: lockstep x enable x boundary, both pins raised together
        for (int ls = 0; ls < 2; ls++) begin
            for (int en = 0; en < 2; en++) begin
                for (int bd = 0; bd < 2; bd++) begin
                    lat = (ls != 0) ? 3 : SYNC_STAGES + 2;
                    do_reset(ls[0], 1'b1);
                    int_en = en[0]; insn_boundary = bd[0]; ack_ready = 1'b1;
                    base = hs;
                    lpin = 2'b11;
                    step(lat - 1);
                    chk("R2 ack early", int'(ack_valid), 0);
                    chk("R9 nmi early", int'(nmi_take), 0);
                    step(1);
                    chk("R2/R3/R4 ack at latency", int'(ack_valid), en & bd);
                    chk("R9 nmi at latency", int'(nmi_take), bd);
                    if (en != 0 && bd != 0) begin
                        step(1);
                        chk("R5 ack low after handshake", int'(ack_valid), 0);
                    end
                    int_en = 1'b1; insn_boundary = 1'b1;
                    step(1);
                    chk("R3 ack after enable", int'(ack_valid), (en & bd) == 0 ? 1 : 0);
                    chk("R9 nmi after boundary", int'(nmi_take), bd == 0 ? 1 : 0);
                    step(8);
                    chk("R6 single handshake", hs - base, 1);
                end
            end
        end

        // R5 backpressure, then R7 re-arm behaviour
        do_reset(1'b0, 1'b1);
        int_en = 1'b1; insn_boundary = 1'b1; ack_ready = 1'b0;
        base = hs;
        lpin = 2'b01;
        step(4);
        chk("R5 ack raised", int'(ack_valid), 1);
        step(3);
        chk("R5 ack held under stall", int'(ack_valid), 1);
        ack_ready = 1'b1;
        step(1);
        chk("R5 ack dropped", int'(ack_valid), 0);
        chk("R5 handshake count", hs - base, 1);
        lpin = 2'b00;
        step(1);
        lpin = 2'b01;
        step(8);
        chk("R7 glitch no rearm", hs - base, 1);
        lpin = 2'b00;
        step(6);
        lpin = 2'b01;
        step(4);
        chk("R7 rearmed ack", int'(ack_valid), 1);
        step(2);
        chk("R7 second handshake", hs - base, 2);

        // R8 withdrawn request; R7 single low does not withdraw
        do_reset(1'b0, 1'b1);
        insn_boundary = 1'b1; ack_ready = 1'b1;
        base = hs;
        lpin = 2'b01;
        step(6);
        lpin = 2'b00;
        step(6);
        int_en = 1'b1;
        step(6);
        chk("R8 no ack after withdraw", int'(ack_valid), 0);
        chk("R8 no handshake", hs - base, 0);
        int_en = 1'b0;
        lpin = 2'b01;
        step(6);
        lpin = 2'b00;
        step(1);
        lpin = 2'b01;
        step(6);
        int_en = 1'b1;
        step(1);
        chk("R7 pending survives one low", int'(ack_valid), 1);

        // R10 local routing
        do_reset(1'b0, 1'b0);
        int_en = 1'b1; insn_boundary = 1'b1; ack_ready = 1'b1;
        base = hs;
        lpin = 2'b01;
        step(1);
        chk("R10 lint before sync", int'(lint_out), 0);
        step(1);
        chk("R10 lint bit0", int'(lint_out), 1);
        lpin = 2'b10;
        step(2);
        chk("R10 lint bit1", int'(lint_out), 2);
        chk("R10 no nmi local", int'(nmi_take), 0);
        lpin = 2'b11;
        step(6);
        chk("R10 no ack local", hs - base, 0);
        chk("R10 no nmi local later", int'(nmi_take), 0);
        route_legacy = 1'b1;
        lpin = 2'b00;
        step(1);
        chk("R10 lint zero legacy", int'(lint_out), 0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        wait (cyc > 20000);
        failures++;
        checks++;
        $display("FAIL watchdog: actual=%0d expected=<20000", cyc);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule